// File: doc/BRIEF.md
# Alignment Fault Detector and Exception State Capture

This block sits beside the load/store pipeline of a 32-bit processor core. For each memory instruction that is presented with a request strobe, it decides whether the access must raise an alignment fault. When the fault is taken, the block loads five machine registers in the same clock edge:

- the save/restore pair (return address and saved machine state);
- the new machine state;
- the fault syndrome;
- the faulting data address.

Instruction decode, address generation, vectoring to the handler and emulation of the access are done elsewhere.

The caller supplies the following with the strobe:

- the 32-bit instruction word;
- an access class code;
- a form bit, which says whether the instruction uses register-indirect-with-index addressing or register-plus-displacement addressing;
- the effective address;
- the page attributes;
- the current machine state word;
- the instruction address.

All bit numbering in this brief is big-endian: bit 0 is the most significant bit of a 32-bit word. Ordinary integer loads and stores never fault on misalignment, because the core handles them in hardware. This holds in either byte order.

Top module: `align_fault_unit`

## Requirements
- R1: An access of class 2 (external-control word transfer) whose effective address has either of its two low-order bits set raises `fault_o` for one cycle after the request edge; a word-aligned one does not.
- R2: An access of class 1 (cache-block zero) whose page is marked write-through or caching-inhibited raises `fault_o`; with neither attribute set, it does not.
- R3: An access of class 3 (load/store multiple) or class 4 (load-reserve/store-conditional) faults when its effective address is not word-aligned.
- R4: An access of class 0 or of any class code from 5 to 7 is an ordinary access. It never faults, whatever its alignment and whatever the little-endian bit (MSR bit 31) holds. After such an access all five registers keep their values.
- R5: On a fault, `srr0_o` takes the instruction address. `srr1_o` bits 16–31 take MSR bits 16–31 and `srr1_o` bits 0–15 are cleared.
- R6: On a fault, `msr_o` is the current MSR with the following bits cleared: 13, 14, 16, 17, 18, 20, 21, 22, 23, 26, 27 and 30. Bit 31 (little-endian) is set equal to bit 15 (exception little-endian), and every other bit is kept.
- R7: In indexed form (`idx_form_i`=1), the fault syndrome is built as follows:
  - bits 0–14 are zero;
  - bits 15–16 take instruction bits 29–30;
  - bit 17 takes instruction bit 25;
  - bits 18–21 take instruction bits 21–24;
  - bits 22–26 take instruction bits 6–10;
  - bits 27–31 take instruction bits 11–15.
- R8: In displacement form (`idx_form_i`=0), the fault syndrome is built as follows:
  - bits 0–16 are zero;
  - bit 17 takes instruction bit 5;
  - bits 18–21 take instruction bits 1–4;
  - bits 22–26 and 27–31 are filled as in R7.
- R9: For a cache-block-zero fault, syndrome bits 22–26 are zero.
- R10: On a fault, `dar_o` takes the effective address, or the effective address plus 4 when the access is of class 3 or 4.
- R11: Reset clears all five registers and `fault_o`. In any cycle without a fault, including idle cycles and cycles just after a fault, the registers hold their values and `fault_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A memory instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| cls_i | input | 3 | Access class: 0 ordinary, 1 cache-block zero, 2 external-control word, 3 multiple, 4 reserve/conditional, 5–7 ordinary |
| idx_form_i | input | 1 | 1 = indexed addressing, 0 = displacement addressing |
| ea_i | input | 32 | Effective address |
| wt_i | input | 1 | Page is write-through |
| ci_i | input | 1 | Page is caching-inhibited |
| msr_i | input | 32 | Current machine state word |
| cia_i | input | 32 | Address of the instruction |
| fault_o | output | 1 | Fault taken on the previous edge |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state |
| msr_o | output | 32 | Machine state written on the fault |
| dsisr_o | output | 32 | Fault syndrome |
| dar_o | output | 32 | Faulting data address |

## Verification
Every result of this block comes out of a single register stage. `fault_o` and all five registers therefore show the outcome of a request exactly one rising edge after the edge that sampled it. Two rising edges later, `fault_o` is low again and the registers hold.

The bench drives a request on a falling edge and removes it on the next falling edge. At that same point it compares every output against values it derives itself, using big-endian bit indexing. For faulting cases it runs one idle cycle and checks again at the following falling edge, which confirms the one-cycle pulse and that the registers hold.

// File: rtl/afu_pkg.sv
package afu_pkg;
  localparam int unsigned XW       = 32;
  localparam int unsigned WORD_B   = 4;
  localparam int unsigned ALIGN_LB = $clog2(WORD_B);

  localparam logic [2:0] CL_PLAIN = 3'd0;
  localparam logic [2:0] CL_DCBZ  = 3'd1;
  localparam logic [2:0] CL_ECW   = 3'd2;
  localparam logic [2:0] CL_MULTI = 3'd3;
  localparam logic [2:0] CL_RSV   = 3'd4;

  // big-endian machine-state positions used by the fault update
  localparam int unsigned MB_ILE = 15;
  localparam int unsigned MB_LE  = 31;

  function automatic int unsigned lsb(input int unsigned be_pos);
    return XW - 1 - be_pos;
  endfunction

  function automatic logic [XW-1:0] be_bit(input int unsigned be_pos);
    logic [XW-1:0] v;
    v = '0;
    v[lsb(be_pos)] = 1'b1;
    return v;
  endfunction

  function automatic logic [XW-1:0] msr_clear_mask();
    return be_bit(13) | be_bit(14) | be_bit(16) | be_bit(17) |
           be_bit(18) | be_bit(20) | be_bit(21) | be_bit(22) |
           be_bit(23) | be_bit(26) | be_bit(27) | be_bit(30);
  endfunction

  function automatic logic [XW-1:0] msr_on_fault(input logic [XW-1:0] m);
    logic [XW-1:0] r;
    r = m & ~msr_clear_mask();
    r[lsb(MB_LE)] = m[lsb(MB_ILE)];
    return r;
  endfunction

  function automatic logic [XW-1:0] srr1_on_fault(input logic [XW-1:0] m);
    return {{(XW/2){1'b0}}, m[XW/2-1:0]};
  endfunction

  function automatic logic [XW-1:0] syndrome(input logic [XW-1:0] ins,
                                             input logic idx,
                                             input logic blank_rs);
    logic [XW-1:0] d;
    d = '0;
    d[4:0] = ins[20:16];
    d[9:5] = blank_rs ? 5'd0 : ins[25:21];
    if (idx) begin
      d[16:15] = ins[2:1];
      d[14]    = ins[6];
      d[13:10] = ins[10:7];
    end else begin
      d[14]    = ins[26];
      d[13:10] = ins[30:27];
    end
    return d;
  endfunction
endpackage

// File: rtl/afu_detect.sv
module afu_detect
  import afu_pkg::*;
(
  input  logic [2:0]          cls,
  input  logic [ALIGN_LB-1:0] ea_lo,
  input  logic                wt,
  input  logic                ci,
  output logic                hit,
  output logic                dar_bump
);
  logic off_word;
  logic word_only;

  assign off_word  = |ea_lo;
  assign word_only = (cls == CL_MULTI) || (cls == CL_RSV);

  always_comb begin
    unique case (cls)
      CL_ECW:          hit = off_word;
      CL_DCBZ:         hit = wt | ci;
      CL_MULTI, CL_RSV: hit = off_word;
      default:         hit = 1'b0;
    endcase
  end

  assign dar_bump = word_only & off_word;
endmodule

// File: rtl/afu_next.sv
module afu_next
  import afu_pkg::*;
(
  input  logic [XW-1:0] instr,
  input  logic          idx_form,
  input  logic [2:0]    cls,
  input  logic [XW-1:0] ea,
  input  logic          dar_bump,
  input  logic [XW-1:0] msr_cur,
  input  logic [XW-1:0] cia,
  output logic [XW-1:0] n_srr0,
  output logic [XW-1:0] n_srr1,
  output logic [XW-1:0] n_msr,
  output logic [XW-1:0] n_dsisr,
  output logic [XW-1:0] n_dar
);
  assign n_srr0  = cia;
  assign n_srr1  = srr1_on_fault(msr_cur);
  assign n_msr   = msr_on_fault(msr_cur);
  assign n_dsisr = syndrome(instr, idx_form, cls == CL_DCBZ);
  assign n_dar   = dar_bump ? ea + XW'(WORD_B) : ea;
endmodule

// File: rtl/align_fault_unit.sv
module align_fault_unit
  import afu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid_i,
  input  logic [31:0]   instr_i,
  input  logic [2:0]    cls_i,
  input  logic          idx_form_i,
  input  logic [31:0]   ea_i,
  input  logic          wt_i,
  input  logic          ci_i,
  input  logic [31:0]   msr_i,
  input  logic [31:0]   cia_i,
  output logic          fault_o,
  output logic [31:0]   srr0_o,
  output logic [31:0]   srr1_o,
  output logic [31:0]   msr_o,
  output logic [31:0]   dsisr_o,
  output logic [31:0]   dar_o
);
  logic          cls_hit;
  logic          dar_bump;
  logic          take_fault;
  logic [XW-1:0] n_srr0, n_srr1, n_msr, n_dsisr, n_dar;

  afu_detect u_detect (
    .cls      (cls_i),
    .ea_lo    (ea_i[ALIGN_LB-1:0]),
    .wt       (wt_i),
    .ci       (ci_i),
    .hit      (cls_hit),
    .dar_bump (dar_bump)
  );

  assign take_fault = req_valid_i & cls_hit;

  afu_next u_next (
    .instr    (instr_i),
    .idx_form (idx_form_i),
    .cls      (cls_i),
    .ea       (ea_i),
    .dar_bump (dar_bump),
    .msr_cur  (msr_i),
    .cia      (cia_i),
    .n_srr0   (n_srr0),
    .n_srr1   (n_srr1),
    .n_msr    (n_msr),
    .n_dsisr  (n_dsisr),
    .n_dar    (n_dar)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_o <= 1'b0;
      srr0_o  <= '0;
      srr1_o  <= '0;
      msr_o   <= '0;
      dsisr_o <= '0;
      dar_o   <= '0;
    end else begin
      fault_o <= take_fault;
      if (take_fault) begin
        srr0_o  <= n_srr0;
        srr1_o  <= n_srr1;
        msr_o   <= n_msr;
        dsisr_o <= n_dsisr;
        dar_o   <= n_dar;
      end
    end
  end
endmodule

// File: rtl/align_fault_unit_chk.sv
module align_fault_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic [2:0]  cls_i,
  input logic [31:0] ea_i,
  input logic        wt_i,
  input logic        ci_i,
  input logic [31:0] msr_i,
  input logic [31:0] cia_i,
  input logic        take_fault,
  input logic        dar_bump,
  input logic        fault_o,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o,
  input logic [31:0] msr_o,
  input logic [31:0] dar_o
);
  p_ecw_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && cls_i == 3'd2 && ea_i[1:0] != 2'b00) |=> fault_o);

  p_dcbz_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && cls_i == 3'd1 && (wt_i || ci_i)) |=> fault_o);

  p_word_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && (cls_i == 3'd3 || cls_i == 3'd4) && ea_i[1:0] != 2'b00)
      |=> fault_o);

  p_plain_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_i == 3'd0 || cls_i > 3'd4) |-> !take_fault);

  p_srr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> (srr0_o == $past(cia_i)) && (srr1_o[31:16] == 16'h0)
                   && (srr1_o[15:0] == $past(msr_i[15:0])));

  p_le_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> (msr_o[0] == $past(msr_i[16])) && !msr_o[15] && !msr_o[1]);

  p_dar_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_fault |=> dar_o == ($past(ea_i) + ($past(dar_bump) ? 32'd4 : 32'd0)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_o |-> $stable(srr0_o) && $stable(msr_o) && $stable(dar_o));
endmodule

bind align_fault_unit align_fault_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid_i (req_valid_i),
  .cls_i       (cls_i),
  .ea_i        (ea_i),
  .wt_i        (wt_i),
  .ci_i        (ci_i),
  .msr_i       (msr_i),
  .cia_i       (cia_i),
  .take_fault  (take_fault),
  .dar_bump    (dar_bump),
  .fault_o     (fault_o),
  .srr0_o      (srr0_o),
  .srr1_o      (srr1_o),
  .msr_o       (msr_o),
  .dar_o       (dar_o)
);

// File: tb/align_fault_unit_test.sv
module align_fault_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [2:0]  cls_i = '0;
  logic        idx_form_i = 1'b0;
  logic [31:0] ea_i = '0;
  logic        wt_i = 1'b0;
  logic        ci_i = 1'b0;
  logic [31:0] msr_i = '0;
  logic [31:0] cia_i = '0;
  logic        fault_o;
  logic [31:0] srr0_o, srr1_o, msr_o, dsisr_o, dar_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] e_srr0 = '0, e_srr1 = '0, e_msr = '0, e_dsisr = '0, e_dar = '0;

  always #2 clk = ~clk;

  align_fault_unit uut (.*);

  function automatic logic bb(input logic [31:0] x, input int k);
    return x[31-k];
  endfunction

  function automatic logic [31:0] exp_dsisr(input logic [31:0] ins, input logic idx,
                                            input logic dz);
    logic [31:0] d;
    d = '0;
    for (int k = 0; k < 32; k++) begin
      logic b;
      b = 1'b0;
      if (k >= 27)                 b = bb(ins, 11 + k - 27);
      else if (k >= 22)            b = dz ? 1'b0 : bb(ins, 6 + k - 22);
      else if (k >= 18)            b = idx ? bb(ins, 21 + k - 18) : bb(ins, 1 + k - 18);
      else if (k == 17)            b = idx ? bb(ins, 25) : bb(ins, 5);
      else if (k >= 15 && idx)     b = bb(ins, 29 + k - 15);
      d[31-k] = b;
    end
    return d;
  endfunction

  function automatic logic [31:0] exp_msr(input logic [31:0] m);
    logic [31:0] r;
    r = m;
    for (int k = 0; k < 32; k++) begin
      if (k == 13 || k == 14 || k == 16 || k == 17 || k == 18 || k == 20 ||
          k == 21 || k == 22 || k == 23 || k == 26 || k == 27 || k == 30)
        r[31-k] = 1'b0;
    end
    r[31-31] = bb(m, 15);
    return r;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp_fault);
    cmp(req, "fault", {31'd0, fault_o}, {31'd0, exp_fault});
    cmp(req, "srr0", srr0_o, e_srr0);
    cmp(req, "srr1", srr1_o, e_srr1);
    cmp(req, "msr", msr_o, e_msr);
    cmp(req, "dsisr", dsisr_o, e_dsisr);
    cmp(req, "dar", dar_o, e_dar);
  endtask

  task automatic issue(input string req, input logic [2:0] cls, input logic idx,
                       input logic [31:0] ins, input logic [31:0] ea,
                       input logic wt, input logic ci, input logic [31:0] m,
                       input logic [31:0] cia, input logic want);
    @(negedge clk);
    req_valid_i = 1'b1; cls_i = cls; idx_form_i = idx; instr_i = ins;
    ea_i = ea; wt_i = wt; ci_i = ci; msr_i = m; cia_i = cia;
    if (want) begin
      e_srr0  = cia;
      e_srr1  = {16'h0, m[15:0]};
      e_msr   = exp_msr(m);
      e_dsisr = exp_dsisr(ins, idx, cls == 3'd1);
      e_dar   = (cls == 3'd3 || cls == 3'd4) ? ea + 32'd4 : ea;
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    check_all(req, want);
    if (want) begin
      @(negedge clk);
      check_all({req, "/R11 after"}, 1'b0);
    end
  endtask

  task automatic t_reset();
    check_all("R11 reset", 1'b0);
  endtask

  task automatic t_ecw();
    issue("R1 aligned", 3'd2, 1'b1, 32'h7C22_1A6C, 32'h0000_1000, 0, 0, 32'h0000_8000, 32'h100, 1'b0);
    issue("R1/R7/R5/R6 misaligned", 3'd2, 1'b1, 32'h7C22_1A6C, 32'h0000_1002, 0, 0,
          32'hFFFF_FFFF, 32'h0000_2004, 1'b1);
  endtask

  task automatic t_dcbz();
    issue("R2 cached", 3'd1, 1'b1, 32'h7C03_27EC, 32'h0000_3000, 0, 0, 32'h0, 32'h200, 1'b0);
    issue("R2/R9 write-through", 3'd1, 1'b1, 32'h7FE3_27EC, 32'h0000_3040, 1, 0,
          32'h0001_0000, 32'h0000_2108, 1'b1);
    issue("R2/R9 inhibited", 3'd1, 1'b1, 32'hFFFF_FFFF, 32'h0000_3080, 0, 1,
          32'h0000_0001, 32'h0000_210C, 1'b1);
  endtask

  task automatic t_multi_rsv();
    issue("R3/R8/R10 multiple", 3'd3, 1'b0, 32'hBBE1_FFF6, 32'h0000_4001, 0, 0,
          32'h0001_B032, 32'h0000_3000, 1'b1);
    issue("R3/R7/R10 reserve", 3'd4, 1'b1, 32'h7CA6_3828, 32'hFFFF_FFFE, 0, 0,
          32'hA5A5_5A5A, 32'h0000_3004, 1'b1);
    issue("R3 multiple aligned", 3'd3, 1'b0, 32'hBBE1_FFF6, 32'h0000_4004, 0, 0,
          32'h0, 32'h0000_3008, 1'b0);
    issue("R8 displacement fields", 3'd3, 1'b0, 32'h5555_AAAA, 32'h0000_5003, 0, 0,
          32'h0000_7FFF, 32'h0000_300C, 1'b1);
  endtask

  task automatic t_plain();
    issue("R4 plain misaligned LE", 3'd0, 1'b1, 32'h7C22_182E, 32'h0000_6001, 1, 1,
          32'h0000_0001, 32'h0000_4000, 1'b0);
    issue("R4 plain misaligned BE", 3'd0, 1'b0, 32'h8022_0003, 32'h0000_6003, 0, 0,
          32'h0, 32'h0000_4004, 1'b0);
    issue("R4 class 7", 3'd7, 1'b1, 32'hFFFF_FFFF, 32'h0000_6001, 1, 1,
          32'hFFFF_FFFF, 32'h0000_4008, 1'b0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    cls_i = 3'd2; ea_i = 32'h3; msr_i = 32'h1234_5678; cia_i = 32'hDEAD_BEEF;
    @(negedge clk);
    check_all("R11 idle no strobe", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_ecw();
    t_dcbz();
    t_multi_rsv();
    t_plain();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule